// File: doc/BRIEF.md
# Convolution Weight Channel-Group Address Generator

This block walks a convolution weight tensor of shape (ic, oc, kh, kw) in its plain source order and, for every element, produces the place where that element must land in a lane-partitioned local memory. In the destination arrangement, input channels are packed innermost in fixed groups. The group holds 64 channels when the weights are 8-bit and 32 channels when they are 16-bit. The kernel window position sits above the in-group channel, and the group index sits above the window position. Each output channel is given to one lane, and output channels that share a lane are stacked one channel-stride apart.

Software or a sequencer loads the kernel dimensions and the element type and pulses start. The block then streams one beat per element over a valid/ready interface. Each beat carries the source element index, the destination lane and the element offset within that lane. When ic is not a multiple of the group size, the block also emits zero-fill beats for the missing channels of the last group, marked by a pad flag. A one-cycle done pulse closes the run. The block moves no data. A companion copy engine consumes the beats.

Top module: `kcg_reorder`

## Requirements
- R1: After reset, out_valid and done are 0.
- R2: Real (non-pad) beats come out in source order, with input channel outermost, then output channel, then kernel row, and kernel column innermost. out_src = ((i*oc + o)*kh + y)*kw + x, which counts 0, 1, 2, ... through the run.
- R3: With cfg_elem = 0 (8-bit) the group size G is 64. With cfg_elem = 1 (16-bit) G is 32.
- R4: out_off = (o div LANES)*CS + (i div G)*G*kw*kh + y*G*kw + x*G + (i mod G), where CS = G*kw*kh*ceil(ic/G).
- R5: out_lane = o mod LANES.
- R6: Input channel i runs up to ceil(ic/G)*G - 1. Beats with i >= ic have out_pad = 1 and out_src = 0, and they follow every real beat. The run has exactly ceil(ic/G)*G*oc*kh*kw beats.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and every beat field holds its value.
- R8: done is 1 for exactly one cycle, in the cycle after the last beat is accepted, and out_valid is 0 in that cycle.
- R9: A start that arrives while a run is in progress or a beat is pending is ignored. The run in progress continues unchanged.
- R10: A start with any of ic, oc, kh or kw equal to 0 produces no beat, and done is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when the block is idle |
| cfg_ic | input | DIM_W | Input channel count |
| cfg_oc | input | DIM_W | Output channel count |
| cfg_kh | input | K_W | Kernel height |
| cfg_kw | input | K_W | Kernel width |
| cfg_elem | input | 1 | Element type: 0 = 8-bit, 1 = 16-bit |
| out_valid | output | 1 | Beat available |
| out_ready | input | 1 | Consumer accepts the beat |
| out_src | output | SRC_W | Source element index (0 for pad beats) |
| out_lane | output | $clog2(LANES) | Destination lane |
| out_off | output | OFF_W | Destination element offset within the lane |
| out_pad | output | 1 | Beat is a zero-fill entry |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench sweeps every beat of several small configurations, with the lane count reduced to 4 so that output channels wrap into higher slots. An 8-bit run with ic = 3 has a group far larger than ic. It separates the two group sizes and exercises heavy padding. A 16-bit run with ic = 33 produces a second group that is almost entirely padding, which tests the group stride and the ceiling. A run with ic equal to the group size must produce no pad beats. A single-channel run with a 1x1 window isolates the in-group channel term. Pseudo-random backpressure on two of the runs checks that beats hold, and a start pulse injected mid-run together with a zero-dimension start covers the start rules.

// File: rtl/kcg_pkg.sv
package kcg_pkg;
  // element type selects the channel group size
  typedef enum logic {
    ELEM_B8  = 1'b0,
    ELEM_B16 = 1'b1
  } kcg_elem_e;

  localparam int unsigned GRP_SH_B8  = 6; // 64 channels per group
  localparam int unsigned GRP_SH_B16 = 5; // 32 channels per group

  function automatic logic [2:0] grp_shift(kcg_elem_e e);
    return (e == ELEM_B16) ? 3'(GRP_SH_B16) : 3'(GRP_SH_B8);
  endfunction
endpackage

// File: rtl/kcg_walker.sv
module kcg_walker
  import kcg_pkg::*;
#(
  parameter int DIM_W = 8,
  parameter int K_W   = 4,
  parameter int OFF_W = 32,
  localparam int I_W  = DIM_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_ok,
  input  logic [DIM_W-1:0] ic,
  input  logic [DIM_W-1:0] oc,
  input  logic [K_W-1:0]   kh,
  input  logic [K_W-1:0]   kw,
  input  kcg_elem_e        elem,
  input  logic             step,
  output logic             busy,
  output logic             zero_hit,
  output logic [I_W-1:0]   cur_i,
  output logic [DIM_W-1:0] cur_o,
  output logic [K_W-1:0]   cur_y,
  output logic [K_W-1:0]   cur_x,
  output logic             cur_last,
  output logic [DIM_W-1:0] lat_ic,
  output logic [DIM_W-1:0] lat_oc,
  output logic [K_W-1:0]   lat_kh,
  output logic [K_W-1:0]   lat_kw,
  output logic [2:0]       lat_sh,
  output logic [OFF_W-1:0] gstride,
  output logic [OFF_W-1:0] cstride
);
  logic [2:0]       sh_in;
  logic [I_W-1:0]   gmask_in;
  logic [I_W-1:0]   ngroups_in;
  logic [I_W-1:0]   icp_in;
  logic [OFF_W-1:0] gstride_in;
  logic [OFF_W-1:0] cstride_in;
  logic [I_W-1:0]   icp_m1;
  logic             any_zero;

  always_comb begin
    sh_in      = grp_shift(elem);
    gmask_in   = (I_W'(1) << sh_in) - I_W'(1);
    ngroups_in = (I_W'(ic) + gmask_in) >> sh_in;
    icp_in     = ngroups_in << sh_in;
    gstride_in = (OFF_W'(kh) * OFF_W'(kw)) << sh_in;
    cstride_in = gstride_in * OFF_W'(ngroups_in);
    any_zero   = (ic == '0) || (oc == '0) || (kh == '0) || (kw == '0);
    zero_hit   = start_ok && any_zero;
    cur_last   = (cur_i == icp_m1) && (cur_o == lat_oc - 1'b1) &&
                 (cur_y == lat_kh - 1'b1) && (cur_x == lat_kw - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cur_i   <= '0;
      cur_o   <= '0;
      cur_y   <= '0;
      cur_x   <= '0;
      lat_ic  <= '0;
      lat_oc  <= '0;
      lat_kh  <= '0;
      lat_kw  <= '0;
      lat_sh  <= '0;
      icp_m1  <= '0;
      gstride <= '0;
      cstride <= '0;
    end else if (start_ok) begin
      busy    <= !any_zero;
      cur_i   <= '0;
      cur_o   <= '0;
      cur_y   <= '0;
      cur_x   <= '0;
      lat_ic  <= ic;
      lat_oc  <= oc;
      lat_kh  <= kh;
      lat_kw  <= kw;
      lat_sh  <= sh_in;
      icp_m1  <= icp_in - I_W'(1);
      gstride <= gstride_in;
      cstride <= cstride_in;
    end else if (step) begin
      if (cur_last) begin
        busy <= 1'b0;
      end else if (cur_x != lat_kw - 1'b1) begin
        cur_x <= cur_x + 1'b1;
      end else begin
        cur_x <= '0;
        if (cur_y != lat_kh - 1'b1) begin
          cur_y <= cur_y + 1'b1;
        end else begin
          cur_y <= '0;
          if (cur_o != lat_oc - 1'b1) begin
            cur_o <= cur_o + 1'b1;
          end else begin
            cur_o <= '0;
            cur_i <= cur_i + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/kcg_addr.sv
module kcg_addr #(
  parameter int LANES  = 64,
  parameter int DIM_W  = 8,
  parameter int K_W    = 4,
  parameter int OFF_W  = 32,
  parameter int SRC_W  = 32,
  localparam int I_W    = DIM_W + 1,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [I_W-1:0]    cur_i,
  input  logic [DIM_W-1:0]  cur_o,
  input  logic [K_W-1:0]    cur_y,
  input  logic [K_W-1:0]    cur_x,
  input  logic [DIM_W-1:0]  lat_ic,
  input  logic [DIM_W-1:0]  lat_oc,
  input  logic [K_W-1:0]    lat_kh,
  input  logic [K_W-1:0]    lat_kw,
  input  logic [2:0]        lat_sh,
  input  logic [OFF_W-1:0]  gstride,
  input  logic [OFF_W-1:0]  cstride,
  output logic [SRC_W-1:0]  src,
  output logic [LANE_W-1:0] lane,
  output logic [OFF_W-1:0]  off,
  output logic              pad
);
  logic [I_W-1:0]   gmask;
  logic [I_W-1:0]   grp;
  logic [I_W-1:0]   inner;
  logic [OFF_W-1:0] slot;
  logic [OFF_W-1:0] win;
  logic [SRC_W-1:0] src_raw;

  always_comb begin
    pad     = cur_i >= I_W'(lat_ic);
    gmask   = (I_W'(1) << lat_sh) - I_W'(1);
    grp     = cur_i >> lat_sh;
    inner   = cur_i & gmask;
    lane    = cur_o[LANE_W-1:0];
    slot    = OFF_W'(cur_o >> LANE_W);
    win     = (OFF_W'(cur_y) * OFF_W'(lat_kw) + OFF_W'(cur_x)) << lat_sh;
    off     = slot * cstride + OFF_W'(grp) * gstride + win + OFF_W'(inner);
    src_raw = ((SRC_W'(cur_i) * SRC_W'(lat_oc) + SRC_W'(cur_o)) * SRC_W'(lat_kh)
               + SRC_W'(cur_y)) * SRC_W'(lat_kw) + SRC_W'(cur_x);
    src     = pad ? '0 : src_raw;
  end
endmodule

// File: rtl/kcg_reorder.sv
module kcg_reorder
  import kcg_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int DIM_W  = 8,
  parameter int K_W    = 4,
  parameter int OFF_W  = 32,
  parameter int SRC_W  = 32,
  localparam int I_W    = DIM_W + 1,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DIM_W-1:0]  cfg_ic,
  input  logic [DIM_W-1:0]  cfg_oc,
  input  logic [K_W-1:0]    cfg_kh,
  input  logic [K_W-1:0]    cfg_kw,
  input  logic              cfg_elem,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SRC_W-1:0]  out_src,
  output logic [LANE_W-1:0] out_lane,
  output logic [OFF_W-1:0]  out_off,
  output logic              out_pad,
  output logic              done
);
  logic             busy, zero_hit, cur_last, start_ok, step, beat_last;
  logic [I_W-1:0]   cur_i;
  logic [DIM_W-1:0] cur_o, lat_ic, lat_oc;
  logic [K_W-1:0]   cur_y, cur_x, lat_kh, lat_kw;
  logic [2:0]       lat_sh;
  logic [OFF_W-1:0] gstride, cstride, nxt_off;
  logic [SRC_W-1:0] nxt_src;
  logic [LANE_W-1:0] nxt_lane;
  logic             nxt_pad;

  assign start_ok = start && !busy && !out_valid;
  assign step     = busy && (!out_valid || out_ready);

  kcg_walker #(.DIM_W(DIM_W), .K_W(K_W), .OFF_W(OFF_W)) u_walk (
    .clk(clk), .rst(rst), .start_ok(start_ok),
    .ic(cfg_ic), .oc(cfg_oc), .kh(cfg_kh), .kw(cfg_kw),
    .elem(kcg_elem_e'(cfg_elem)), .step(step),
    .busy(busy), .zero_hit(zero_hit),
    .cur_i(cur_i), .cur_o(cur_o), .cur_y(cur_y), .cur_x(cur_x),
    .cur_last(cur_last),
    .lat_ic(lat_ic), .lat_oc(lat_oc), .lat_kh(lat_kh), .lat_kw(lat_kw),
    .lat_sh(lat_sh), .gstride(gstride), .cstride(cstride)
  );

  kcg_addr #(.LANES(LANES), .DIM_W(DIM_W), .K_W(K_W), .OFF_W(OFF_W),
             .SRC_W(SRC_W)) u_addr (
    .cur_i(cur_i), .cur_o(cur_o), .cur_y(cur_y), .cur_x(cur_x),
    .lat_ic(lat_ic), .lat_oc(lat_oc), .lat_kh(lat_kh), .lat_kw(lat_kw),
    .lat_sh(lat_sh), .gstride(gstride), .cstride(cstride),
    .src(nxt_src), .lane(nxt_lane), .off(nxt_off), .pad(nxt_pad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_src   <= '0;
      out_lane  <= '0;
      out_off   <= '0;
      out_pad   <= 1'b0;
      beat_last <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= (out_valid && out_ready && beat_last) || zero_hit;
      if (step) begin
        out_valid <= 1'b1;
        out_src   <= nxt_src;
        out_lane  <= nxt_lane;
        out_off   <= nxt_off;
        out_pad   <= nxt_pad;
        beat_last <= cur_last;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/kcg_reorder_chk.sv
module kcg_reorder_chk #(
  parameter int SRC_W  = 32,
  parameter int OFF_W  = 32,
  parameter int LANE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              out_valid,
  input logic              out_ready,
  input logic [SRC_W-1:0]  out_src,
  input logic [LANE_W-1:0] out_lane,
  input logic [OFF_W-1:0]  out_off,
  input logic              out_pad,
  input logic              beat_last,
  input logic              done
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_src) && $stable(out_lane)
      && $stable(out_off) && $stable(out_pad)); // R7

  AST_PAD_SRC_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_pad |-> out_src == '0); // R6

  AST_PAD_TAIL: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_pad && !beat_last |=> !out_valid || out_pad); // R6

  AST_SRC_STEP: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !out_pad && !beat_last |=>
      !out_valid || out_pad || (out_src - $past(out_src) == SRC_W'(1))); // R2

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_valid); // R8
endmodule

bind kcg_reorder kcg_reorder_chk #(.SRC_W(SRC_W), .OFF_W(OFF_W), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_src(out_src), .out_lane(out_lane), .out_off(out_off), .out_pad(out_pad),
  .beat_last(beat_last), .done(done)
);

// File: tb/kcg_reorder_test.sv
module kcg_reorder_test;
  localparam int LANES = 4;
  localparam int DIM_W = 8;
  localparam int K_W   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [DIM_W-1:0] cfg_ic = '0, cfg_oc = '0;
  logic [K_W-1:0]   cfg_kh = '0, cfg_kw = '0;
  logic cfg_elem = 1'b0;
  logic out_valid, out_ready, out_pad, done;
  logic [31:0] out_src, out_off;
  logic [1:0]  out_lane;

  int checks = 0;
  int errors = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit bp_on = 0;
  bit inject = 0;
  int beat_k = 0;
  bit stall_prev = 0;
  logic [31:0] h_src, h_off;
  logic [1:0]  h_lane;
  logic        h_pad;

  kcg_reorder #(.LANES(LANES), .DIM_W(DIM_W), .K_W(K_W)) uut (
    .clk(clk), .rst(rst), .start(start),
    .cfg_ic(cfg_ic), .cfg_oc(cfg_oc), .cfg_kh(cfg_kh), .cfg_kw(cfg_kw),
    .cfg_elem(cfg_elem), .out_valid(out_valid), .out_ready(out_ready),
    .out_src(out_src), .out_lane(out_lane), .out_off(out_off),
    .out_pad(out_pad), .done(done)
  );

  always #5 clk = ~clk;

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // wait for one accepted beat and compare it
  task automatic take_beat(int e_src, int e_lane, int e_off, bit e_pad);
    bit got = 0;
    while (!got) begin
      @(negedge clk);
      if (stall_prev) begin
        check(out_valid && out_src == h_src && out_off == h_off &&
              out_lane == h_lane && out_pad == h_pad, "R7 held beat",
              longint'(out_off), longint'(h_off));
      end
      if (inject && beat_k == 5) begin
        start = 1'b1; cfg_ic = 8'd1; cfg_oc = 8'd1; cfg_kh = 4'd1; cfg_kw = 4'd1;
      end else begin
        start = 1'b0;
      end
      out_ready = bp_on ? (lfsr[0] | lfsr[3]) : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (out_valid && out_ready) begin
        got = 1;
        stall_prev = 0;
        check(out_src == 32'(e_src), "R2 src", longint'(out_src), longint'(e_src));
        check(out_lane == 2'(e_lane), "R5 lane", longint'(out_lane), longint'(e_lane));
        check(out_off == 32'(e_off), "R4 R3 off", longint'(out_off), longint'(e_off));
        check(out_pad == e_pad, "R6 pad", longint'(out_pad), longint'(e_pad));
      end else begin
        stall_prev = out_valid;
        h_src = out_src; h_off = out_off; h_lane = out_lane; h_pad = out_pad;
      end
    end
    beat_k++;
  endtask

  task automatic run_cfg(bit elem, int ic, int oc, int kh, int kw, bit bp, bit inj);
    int g = elem ? 32 : 64;
    int ng = (ic + g - 1) / g;
    int gs = g * kw * kh;
    int cs = gs * ng;
    @(negedge clk);
    cfg_elem = elem; cfg_ic = 8'(ic); cfg_oc = 8'(oc); cfg_kh = 4'(kh); cfg_kw = 4'(kw);
    start = 1'b1; out_ready = 1'b0;
    bp_on = bp; inject = inj; beat_k = 0; stall_prev = 0;
    for (int i = 0; i < ng * g; i++)
      for (int o = 0; o < oc; o++)
        for (int y = 0; y < kh; y++)
          for (int x = 0; x < kw; x++) begin
            bit p = (i >= ic);
            int s = p ? 0 : ((i * oc + o) * kh + y) * kw + x;
            int off = (o / LANES) * cs + (i / g) * gs + y * g * kw + x * g + (i % g);
            take_beat(s, o % LANES, off, p);
          end
    @(negedge clk);
    start = 1'b0;
    out_ready = 1'b0;
    check(done == 1'b1, "R8 R6 done after last beat", longint'(done), 1);
    check(out_valid == 1'b0, "R6 R9 no extra beat", longint'(out_valid), 0);
    @(negedge clk);
    check(done == 1'b0, "R8 done single cycle", longint'(done), 0);
  endtask

  initial begin
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", longint'(out_valid), 0);
    check(done == 1'b0, "R1 done after reset", longint'(done), 0);
    rst = 1'b0;
    // 8-bit, heavy padding, backpressure, mid-run start (R9)
    run_cfg(1'b0, 3, 5, 2, 2, 1'b1, 1'b1);
    // 16-bit, second group mostly padding
    run_cfg(1'b1, 33, 6, 1, 3, 1'b1, 1'b0);
    // 16-bit, ic exactly one group, no pad beats
    run_cfg(1'b1, 32, 2, 3, 2, 1'b0, 1'b0);
    // 8-bit, full group, 1x1 window
    run_cfg(1'b0, 64, 1, 1, 1, 1'b0, 1'b0);
    // R10 zero dimension
    @(negedge clk);
    cfg_ic = 8'd4; cfg_oc = 8'd0; cfg_kh = 4'd1; cfg_kw = 4'd1; start = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R10 done after zero start", longint'(done), 1);
    check(out_valid == 1'b0, "R10 no beat", longint'(out_valid), 0);
    @(negedge clk);
    check(done == 1'b0, "R10 done drops", longint'(done), 0);
    check(out_valid == 1'b0, "R10 still no beat", longint'(out_valid), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule